// File: doc/BRIEF.md
# Isolated Indirect Branch Target Predictor

This block is a small direct-mapped target buffer that supplies predicted destinations for indirect branches on a core that runs two hardware threads. Fetch presents a word address together with the current privilege level and the thread number. In the same cycle the block answers with a hit flag and a predicted target. When a branch resolves, the execute stage writes its address, real target, privilege level and thread back into the buffer.

The buffer is hardened against one context training predictions for another. Every entry remembers the privilege level and the thread that wrote it. A lookup from the other privilege level never matches. While thread isolation is enabled, a lookup from the other thread never matches either. Two control inputs wipe the whole buffer in one clock: a privilege-transition event and a software prediction barrier. A configuration bit, which is set at reset and can be written, selects whether the two threads may share entries.

Top module: `btb_isolated_target_pred`

## Requirements
- R1: While reset is low, and right after it is released, no lookup hits, `lk_target` reads zero and `iso_enabled` reads 1.
- R2: After an accepted update (`up_valid`=1 with neither flush input high) at a rising edge, a lookup with the same address, mode and thread hits and returns the written target.
- R3: A lookup never hits an entry whose recorded mode (0 = user, 1 = kernel) differs from `lk_mode`.
- R4: A cycle with `priv_switch`=1 invalidates every entry at the next rising edge, so that no later lookup hits until a new update is made.
- R5: A cycle with `pred_barrier`=1 invalidates every entry at the next rising edge, whichever mode is current.
- R6: While `iso_enabled`=1, a lookup never hits an entry that was written by the other thread.
- R7: While `iso_enabled`=0, the thread bit is ignored for hits but is still recorded, so an entry that was written under sharing is again private to its writer once isolation is turned back on.
- R8: The entry is selected by address bits [5:2], and the tag is address bits [31:6]. A lookup whose tag differs from the stored tag misses. An update overwrites the selected entry whatever it held before.
- R9: When a flush input and `up_valid` are both high in the same cycle, the flush takes effect and the update is dropped.
- R10: The lookup is combinational. `lk_hit` and `lk_target` follow the lookup inputs with no clock edge, and `lk_target` is zero whenever `lk_hit` is 0.
- R11: A cycle with `cfg_we`=1 loads `cfg_isolate` into the isolation bit at the next rising edge, and `iso_enabled` shows that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | 30 | Fetch word address, address bits [31:2] |
| lk_mode | input | 1 | Current privilege level, 1 = kernel |
| lk_tid | input | 1 | Hardware thread of the lookup |
| lk_hit | output | 1 | Prediction available |
| lk_target | output | 32 | Predicted target, zero on a miss |
| up_valid | input | 1 | Resolved branch write request |
| up_pc | input | 30 | Resolved branch word address |
| up_target | input | 32 | Resolved branch target |
| up_mode | input | 1 | Privilege level at training |
| up_tid | input | 1 | Thread that trained |
| priv_switch | input | 1 | Privilege transition event, flushes all entries |
| pred_barrier | input | 1 | Software prediction barrier, flushes all entries |
| cfg_we | input | 1 | Write enable for the isolation bit |
| cfg_isolate | input | 1 | New isolation bit value |
| iso_enabled | output | 1 | Current isolation bit |

## Verification
The main sweep trains all sixteen slots from one mode and thread pair, then looks up every slot from all four mode and thread pairs. The sweep is repeated for every training pair, once with isolation on and once with it off. This tells mode gating apart from thread gating, and shows that only the thread check depends on the configuration bit. Separate patterns toggle isolation after shared training to show that the thread bit was still recorded. They also alias two addresses onto one slot to cover the tag compare and the overwrite. Flushes are fired alone, in each mode, and in the same cycle as an update, to separate the two flush sources and to show that a flush beats a write.

// File: rtl/btb_pkg.sv
// Shared encodings for the isolated branch target predictor.
// Assumes: single clock domain; mode is one bit (user or kernel).
package btb_pkg;

    typedef enum logic {
        PRIV_USER   = 1'b0,
        PRIV_KERNEL = 1'b1
    } priv_e;

    typedef enum logic [1:0] {
        FL_NONE    = 2'b00,
        FL_PRIV    = 2'b01,
        FL_BARRIER = 2'b10,
        FL_BOTH    = 2'b11
    } flush_src_e;

    // Encodes which flush sources are active this cycle.
    function automatic flush_src_e flush_source(input logic priv_ev, input logic barrier_ev);
        return flush_src_e'({barrier_ev, priv_ev});
    endfunction

endpackage

// File: rtl/btb_iso_cfg.sv
// Holds the cross-thread isolation configuration bit.
// Assumes: enabled out of reset; software writes it through cfg_we.
module btb_iso_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_d,
    output logic iso_q
);

    // Isolation bit register, reset to enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            iso_q <= 1'b1;
        else if (cfg_we)
            iso_q <= cfg_d;
    end

endmodule

// File: rtl/btb_entry_array.sv
// Direct-mapped storage of predictor entries with single-cycle flush.
// Assumes: one write port and one combinational read port; flush beats write.
module btb_entry_array #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 26,
    parameter int TGT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [TGT_W-1:0]   wr_tgt,
    input  logic               wr_mode,
    input  logic               wr_tid,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [TGT_W-1:0]   rd_tgt,
    output logic               rd_mode,
    output logic               rd_tid,
    output logic [ENTRIES-1:0] valid_vec
);

    logic [TAG_W-1:0] tag_mem  [ENTRIES];
    logic [TGT_W-1:0] tgt_mem  [ENTRIES];
    logic             mode_mem [ENTRIES];
    logic             tid_mem  [ENTRIES];

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
            logic sel;
            assign sel = wr_en && (wr_idx == IDX_W'(e));

            // Valid bit: cleared by reset or flush, set by a write.
            always_ff @(posedge clk) begin
                if (!rst_n || flush)
                    valid_vec[e] <= 1'b0;
                else if (sel)
                    valid_vec[e] <= 1'b1;
            end

            // Payload: overwritten unconditionally on a write to this slot.
            always_ff @(posedge clk) begin
                if (sel && !flush) begin
                    tag_mem[e]  <= wr_tag;
                    tgt_mem[e]  <= wr_tgt;
                    mode_mem[e] <= wr_mode;
                    tid_mem[e]  <= wr_tid;
                end
            end
        end
    endgenerate

    // Combinational read of the indexed slot.
    always_comb begin
        rd_valid = valid_vec[rd_idx];
        rd_tag   = tag_mem[rd_idx];
        rd_tgt   = tgt_mem[rd_idx];
        rd_mode  = mode_mem[rd_idx];
        rd_tid   = tid_mem[rd_idx];
    end

endmodule

// File: rtl/btb_hit_check.sv
// Decides whether a read entry may produce a prediction for this context.
// Assumes: mode must always match; thread must match only under isolation.
module btb_hit_check #(
    parameter int TAG_W = 26,
    parameter int TGT_W = 32
) (
    input  logic             rd_valid,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [TGT_W-1:0] rd_tgt,
    input  logic             rd_mode,
    input  logic             rd_tid,
    input  logic [TAG_W-1:0] look_tag,
    input  logic             look_mode,
    input  logic             look_tid,
    input  logic             isolate,
    output logic             hit,
    output logic [TGT_W-1:0] target
);

    logic tag_ok, mode_ok, thread_ok;

    // Per-field match terms and the gated hit.
    always_comb begin
        tag_ok    = (rd_tag == look_tag);
        mode_ok   = (rd_mode == look_mode);
        thread_ok = !isolate || (rd_tid == look_tid);
        hit       = rd_valid && tag_ok && mode_ok && thread_ok;
        target    = hit ? rd_tgt : '0;
    end

endmodule

// File: rtl/btb_isolated_target_pred.sv
// Top of the isolated indirect branch target predictor.
// Assumes: word-aligned PCs (bits [1:0] not supplied); a flush from either
// source drops a same-cycle update.
module btb_isolated_target_pred #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16,
    parameter int TGT_W   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:2] lk_pc,
    input  logic            lk_mode,
    input  logic            lk_tid,
    output logic            lk_hit,
    output logic [TGT_W-1:0] lk_target,
    input  logic            up_valid,
    input  logic [PC_W-1:2] up_pc,
    input  logic [TGT_W-1:0] up_target,
    input  logic            up_mode,
    input  logic            up_tid,
    input  logic            priv_switch,
    input  logic            pred_barrier,
    input  logic            cfg_we,
    input  logic            cfg_isolate,
    output logic            iso_enabled
);
    import btb_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - 2 - IDX_W;

    flush_src_e         fl_src;
    logic               flush_all;
    logic               wr_ok;
    logic [IDX_W-1:0]   up_idx, lk_idx;
    logic [TAG_W-1:0]   up_tag, lk_tag;
    logic               rd_valid, rd_mode, rd_tid;
    logic [TAG_W-1:0]   rd_tag;
    logic [TGT_W-1:0]   rd_tgt;
    logic [ENTRIES-1:0] valid_vec;

    // Address split and flush arbitration.
    always_comb begin
        fl_src    = flush_source(priv_switch, pred_barrier);
        flush_all = (fl_src != FL_NONE);
        wr_ok     = up_valid && !flush_all;
        up_idx    = up_pc[IDX_W+1:2];
        up_tag    = up_pc[PC_W-1:IDX_W+2];
        lk_idx    = lk_pc[IDX_W+1:2];
        lk_tag    = lk_pc[PC_W-1:IDX_W+2];
    end

    btb_iso_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg_we(cfg_we),
        .cfg_d (cfg_isolate),
        .iso_q (iso_enabled)
    );

    btb_entry_array #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush_all),
        .wr_en    (wr_ok),
        .wr_idx   (up_idx),
        .wr_tag   (up_tag),
        .wr_tgt   (up_target),
        .wr_mode  (up_mode),
        .wr_tid   (up_tid),
        .rd_idx   (lk_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt),
        .rd_mode  (rd_mode),
        .rd_tid   (rd_tid),
        .valid_vec(valid_vec)
    );

    btb_hit_check #(.TAG_W(TAG_W), .TGT_W(TGT_W)) u_hit (
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt),
        .rd_mode  (rd_mode),
        .rd_tid   (rd_tid),
        .look_tag (lk_tag),
        .look_mode(lk_mode),
        .look_tid (lk_tid),
        .isolate  (iso_enabled),
        .hit      (lk_hit),
        .target   (lk_target)
    );

endmodule

// File: rtl/btb_checker.sv
// Property checker for the isolated branch target predictor.
// Assumes: bound into btb_isolated_target_pred; sees storage-side read fields.
module btb_checker #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_hit,
    input logic               lk_mode,
    input logic               lk_tid,
    input logic               rd_mode,
    input logic               rd_tid,
    input logic               up_valid,
    input logic [IDX_W-1:0]   up_idx,
    input logic               priv_switch,
    input logic               pred_barrier,
    input logic               cfg_we,
    input logic               cfg_isolate,
    input logic               iso_enabled,
    input logic [ENTRIES-1:0] valid_vec
);

    // R1: right after reset is released nothing hits and isolation is on.
    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_vec == '0) && iso_enabled);

    // R2: an accepted update leaves its slot valid.
    a_r2_update_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !priv_switch && !pred_barrier) |=> valid_vec[$past(up_idx)]);

    // R3: a hit only comes from an entry of the current mode.
    a_r3_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (rd_mode == lk_mode));

    // R4: a privilege transition leaves no valid entry.
    a_r4_priv_flush: assert property (@(posedge clk) disable iff (!rst_n)
        priv_switch |=> (valid_vec == '0) && !lk_hit);

    // R5: a barrier leaves no valid entry.
    a_r5_barrier_flush: assert property (@(posedge clk) disable iff (!rst_n)
        pred_barrier |=> (valid_vec == '0));

    // R6: under isolation a hit only comes from the owning thread.
    a_r6_thread_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && iso_enabled) |-> (rd_tid == lk_tid));

    // R9: a flush together with an update leaves nothing valid.
    a_r9_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((priv_switch || pred_barrier) && up_valid) |=> !valid_vec[$past(up_idx)]);

    // R11: a configuration write lands on the next edge.
    a_r11_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (iso_enabled == $past(cfg_isolate)));

endmodule

bind btb_isolated_target_pred btb_checker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_hit      (lk_hit),
    .lk_mode     (lk_mode),
    .lk_tid      (lk_tid),
    .rd_mode     (rd_mode),
    .rd_tid      (rd_tid),
    .up_valid    (up_valid),
    .up_idx      (up_idx),
    .priv_switch (priv_switch),
    .pred_barrier(pred_barrier),
    .cfg_we      (cfg_we),
    .cfg_isolate (cfg_isolate),
    .iso_enabled (iso_enabled),
    .valid_vec   (valid_vec)
);

// File: tb/sim_btb_isolated_target_pred.sv
// Self-checking sweep bench for the isolated branch target predictor.
module sim_btb_isolated_target_pred;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:2] lk_pc = '0;
    logic        lk_mode = 1'b0, lk_tid = 1'b0;
    logic        lk_hit;
    logic [31:0] lk_target;
    logic        up_valid = 1'b0;
    logic [31:2] up_pc = '0;
    logic [31:0] up_target = '0;
    logic        up_mode = 1'b0, up_tid = 1'b0;
    logic        priv_switch = 1'b0, pred_barrier = 1'b0;
    logic        cfg_we = 1'b0, cfg_isolate = 1'b0;
    logic        iso_enabled;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;  // 50 MHz

    btb_isolated_target_pred u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_mode(lk_mode), .lk_tid(lk_tid),
        .lk_hit(lk_hit), .lk_target(lk_target),
        .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target),
        .up_mode(up_mode), .up_tid(up_tid),
        .priv_switch(priv_switch), .pred_barrier(pred_barrier),
        .cfg_we(cfg_we), .cfg_isolate(cfg_isolate), .iso_enabled(iso_enabled)
    );

    // Word address made from a 26-bit tag and a 4-bit slot.
    function automatic logic [31:2] wa(input int slot, input int hi);
        return {hi[25:0], slot[3:0]};
    endfunction

    // Target chosen so that slot, mode and thread are all visible in it.
    function automatic logic [31:0] tgt(input int slot, input int m, input int t);
        return 32'h4000_0000 + 32'(slot * 'h40) + 32'(m * 'h800) + 32'(t * 'h1000);
    endfunction

    task automatic check(input string req, input logic exp_hit, input logic [31:0] exp_tgt);
        n_vec++;
        if (lk_hit !== exp_hit || lk_target !== exp_tgt) begin
            n_bad++;
            $display("FAIL %s: hit=%0b target=%h expected hit=%0b target=%h",
                     req, lk_hit, lk_target, exp_hit, exp_tgt);
        end
    endtask

    task automatic look(input int slot, input int hi, input int m, input int t);
        lk_pc = wa(slot, hi); lk_mode = m[0]; lk_tid = t[0];
        #1;
    endtask

    task automatic upd(input int slot, input int hi, input int m, input int t, input logic [31:0] d);
        @(negedge clk);
        up_pc = wa(slot, hi); up_target = d; up_mode = m[0]; up_tid = t[0]; up_valid = 1'b1;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic flush(input logic by_priv, input logic by_bar);
        @(negedge clk);
        priv_switch = by_priv; pred_barrier = by_bar;
        @(negedge clk);
        priv_switch = 1'b0; pred_barrier = 1'b0;
    endtask

    task automatic set_iso(input logic v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_isolate = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Train all slots from (m,t), then probe all slots from all four contexts.
    task automatic sweep(input logic iso, input int m, input int t);
        flush(1'b0, 1'b1);
        for (int s = 0; s < 16; s++) upd(s, 'h155 + s, m, t, tgt(s, m, t));
        for (int s = 0; s < 16; s++)
            for (int lm = 0; lm < 2; lm++)
                for (int lt = 0; lt < 2; lt++) begin
                    logic e;
                    e = (lm == m) && (!iso || lt == t);
                    look(s, 'h155 + s, lm, lt);
                    if (lm != m) check("R3 mode gate", e, e ? tgt(s, m, t) : 32'h0);
                    else if (lt != t) check(iso ? "R6 thread gate" : "R7 shared hit", e, e ? tgt(s, m, t) : 32'h0);
                    else check("R2 trained hit", e, e ? tgt(s, m, t) : 32'h0);
                end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, during reset and after release.
        repeat (3) @(negedge clk);
        for (int s = 0; s < 16; s++) begin
            look(s, 0, s % 2, (s / 2) % 2);
            check("R1 reset no hit", 1'b0, 32'h0);
        end
        n_vec++;
        if (iso_enabled !== 1'b1) begin
            n_bad++;
            $display("FAIL R1 reset iso: actual=%0b expected=1", iso_enabled);
        end
        rst_n = 1'b1;
        @(negedge clk);
        look(0, 0, 0, 0);
        check("R1 after release", 1'b0, 32'h0);

        // R2 R3 R6: sweep under isolation.
        for (int m = 0; m < 2; m++)
            for (int t = 0; t < 2; t++) sweep(1'b1, m, t);

        // R11: turn isolation off, check port.
        set_iso(1'b0);
        n_vec++;
        if (iso_enabled !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 cfg write: actual=%0b expected=0", iso_enabled);
        end

        // R3 R7: sweep with sharing allowed.
        for (int m = 0; m < 2; m++)
            for (int t = 0; t < 2; t++) sweep(1'b0, m, t);

        // R7: thread was recorded while shared; re-enabling makes it private.
        set_iso(1'b1);
        for (int s = 0; s < 16; s++) begin
            look(s, 'h155 + s, 1, 1);
            check("R7 owner still hits", 1'b1, tgt(s, 1, 1));
            look(s, 'h155 + s, 1, 0);
            check("R7 recorded tid blocks sibling", 1'b0, 32'h0);
        end

        // R8: alias on one slot; tag compare and overwrite.
        flush(1'b0, 1'b1);
        upd(3, 'h2AAAAAA, 0, 0, 32'hCAFE_0000);
        look(3, 'h1555555, 0, 0);
        check("R8 tag mismatch", 1'b0, 32'h0);
        upd(3, 'h1555555, 1, 1, 32'hBEEF_0004);
        look(3, 'h2AAAAAA, 0, 0);
        check("R8 old entry overwritten", 1'b0, 32'h0);
        look(3, 'h1555555, 1, 1);
        check("R8 new entry hits", 1'b1, 32'hBEEF_0004);

        // R10: combinational lookup, change inputs with no edge.
        @(negedge clk);
        lk_pc = wa(3, 'h1555555); lk_mode = 1'b1; lk_tid = 1'b1; #2;
        check("R10 comb hit", 1'b1, 32'hBEEF_0004);
        lk_mode = 1'b0; #2;
        check("R10 comb miss zero target", 1'b0, 32'h0);

        // R4: privilege transition clears everything.
        for (int s = 0; s < 16; s++) upd(s, 7, s % 2, 0, tgt(s, s % 2, 0));
        flush(1'b1, 1'b0);
        for (int s = 0; s < 16; s++) begin
            look(s, 7, s % 2, 0);
            check("R4 priv flush", 1'b0, 32'h0);
        end

        // R5: barrier clears everything in either mode.
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 16; s++) upd(s, 9, m, 1, tgt(s, m, 1));
            look(5, 9, m, 1);
            check("R5 pre-barrier hit", 1'b1, tgt(5, m, 1));
            flush(1'b0, 1'b1);
            for (int s = 0; s < 16; s++) begin
                look(s, 9, m, 1);
                check("R5 barrier flush", 1'b0, 32'h0);
            end
        end

        // R9: flush and update in one cycle; flush wins.
        for (int k = 0; k < 2; k++) begin
            upd(5, 11, 0, 0, 32'h0000_5550);
            @(negedge clk);
            up_pc = wa(6, 11); up_target = 32'h0000_6660; up_mode = 1'b0; up_tid = 1'b0;
            up_valid = 1'b1; priv_switch = (k == 0); pred_barrier = (k == 1);
            @(negedge clk);
            up_valid = 1'b0; priv_switch = 1'b0; pred_barrier = 1'b0;
            look(6, 11, 0, 0);
            check("R9 update dropped", 1'b0, 32'h0);
            look(5, 11, 0, 0);
            check("R9 flush applied", 1'b0, 32'h0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule